// File: doc/BRIEF.md
# Host Mailbox Command Receiver and Responder

This block connects a host-side register window to the command logic inside a device. The host fills a bank of incoming mailbox words with a command and its parameters. It then writes the most significant byte of the last incoming mailbox. That byte write is the trigger. It takes a copy of all incoming words and presents the copy once to an internal command consumer. The incoming side stays busy until the consumer acknowledges the command. A second trigger that arrives while the block is busy is refused and sets a sticky overrun flag.

Replies travel the other way through a small set of outgoing mailbox words. No interrupt is raised when a reply is written; the host polls the full flags instead. The block only accepts a reply when an acknowledged command asked for one. The request is bit 31 of the last incoming mailbox, which is the top bit of the trigger byte. The block never writes a reply into an outgoing mailbox that the host has not yet read. A reply that nobody asked for is consumed and discarded, and a sticky protocol-error flag is set.

The reply port is valid/ready. A reply is transferred in any cycle where both `resp_valid` and `resp_ready` are high. While a request is outstanding, `resp_ready` is low whenever the selected outgoing mailbox is full. The producer must then hold `resp_valid`, `resp_data` and `resp_sel` stable until `resp_ready` rises. When no request is outstanding, `resp_ready` is high and the reply is dropped.

Top module: `mbox_cmd_resp`

## Requirements
- R1: After reset, `cmd_valid`, `cmd_pending`, `cmd_overrun`, `resp_err`, every `ob_full` bit and `hrd_data` are zero. `resp_ready` is one, because no request is outstanding.
- R2: A host write with `hwr_en` high updates the byte lanes of mailbox `hwr_sel` whose `hwr_be` bits are set. It raises no `cmd_valid` unless it is a trigger write. A trigger write targets the last mailbox with `hwr_be[3]` set.
- R3: After an accepted trigger write, `cmd_valid` is high for exactly one cycle, starting the cycle after the write. At the same time, `cmd_words` holds all incoming words, with the trigger write's own bytes merged in. Mailbox m sits at bits [32m+31:32m].
- R4: A trigger write made while `cmd_pending` is low is accepted, and `cmd_pending` rises with `cmd_valid`. `cmd_pending` falls in the cycle after a `cmd_ack`. A `cmd_ack` given while `cmd_pending` is low has no effect.
- R5: A trigger write made while `cmd_pending` is high sets the sticky `cmd_overrun` flag. It raises no `cmd_valid` and leaves `cmd_words` unchanged.
- R6: Acknowledging a command whose bit 31 of the last mailbox is set adds one outstanding reply request. The count saturates at 2^PEND_W-1. A command with that bit clear adds nothing.
- R7: When a request is outstanding and outgoing mailbox `resp_sel` is empty, `resp_ready` is high. A reply transferred in that state is stored, sets `ob_full[resp_sel]`, and uses up one request.
- R8: When a request is outstanding and outgoing mailbox `resp_sel` is full, `resp_ready` is low and the stored word is kept unchanged.
- R9: A reply offered with no request outstanding is accepted with `resp_ready` high and then discarded. It sets the sticky `resp_err` flag and changes no outgoing mailbox.
- R10: A host read with `hrd_en` high returns outgoing mailbox `hrd_sel` on `hrd_data` in the next cycle, and clears that mailbox's full flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hwr_en | input | 1 | Host write strobe for incoming mailboxes |
| hwr_sel | input | $clog2(NUM_IN) | Incoming mailbox index |
| hwr_be | input | 4 | Byte-lane enables |
| hwr_data | input | 32 | Host write data |
| cmd_valid | output | 1 | One-cycle new-command pulse |
| cmd_words | output | 32*NUM_IN | Captured incoming words |
| cmd_pending | output | 1 | Command captured, not yet acknowledged |
| cmd_ack | input | 1 | Consumer has taken the command |
| cmd_overrun | output | 1 | Sticky: trigger refused while busy |
| resp_valid | input | 1 | Reply offered |
| resp_ready | output | 1 | Reply may transfer this cycle |
| resp_data | input | 32 | Reply word |
| resp_sel | input | $clog2(NUM_OUT) | Target outgoing mailbox |
| resp_err | output | 1 | Sticky: unrequested reply dropped |
| ob_full | output | NUM_OUT | Outgoing mailbox holds unread data |
| hrd_en | input | 1 | Host read strobe for outgoing mailboxes |
| hrd_sel | input | $clog2(NUM_OUT) | Outgoing mailbox index to read |
| hrd_data | output | 32 | Read data, one cycle after `hrd_en` |

## Verification
The bench builds the block with NUM_IN=4, NUM_OUT=2 and PEND_W=2. The narrow request counter saturates at three after four requesting commands, so the saturation corner of R6 can be reached in a few dozen cycles. Two outgoing mailboxes let one reply wait on a full mailbox while the other mailbox takes dropped traffic. This shows that a dropped reply leaves both mailboxes untouched. Four incoming words keep the trigger lane in the same position that the requirements name.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MB_WORD_W  = 32;
  localparam int MB_LANE_W  = 8;
  localparam int MB_LANES   = MB_WORD_W / MB_LANE_W;
  localparam int MB_REQ_BIT = MB_WORD_W - 1;
  typedef logic [MB_WORD_W-1:0] mb_word_t;
endpackage

// File: rtl/mbox_in_bank.sv
module mbox_in_bank
  import mbox_pkg::*;
#(
  parameter int NUM_IN = 4,
  localparam int SEL_W = $clog2(NUM_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [MB_LANES-1:0] wr_be,
  input  mb_word_t         wr_data,
  output mb_word_t         next_words [NUM_IN],
  output logic             trig
);
  // trigger: top lane of the last mailbox
  assign trig = wr_en && (wr_sel == SEL_W'(NUM_IN - 1)) && wr_be[MB_LANES-1];

  for (genvar m = 0; m < NUM_IN; m++) begin : g_box
    mb_word_t cur_q;
    mb_word_t nxt;
    logic     hit;
    assign hit = wr_en && (wr_sel == SEL_W'(m));
    for (genvar b = 0; b < MB_LANES; b++) begin : g_lane
      assign nxt[b*MB_LANE_W +: MB_LANE_W] =
        (hit && wr_be[b]) ? wr_data[b*MB_LANE_W +: MB_LANE_W]
                          : cur_q[b*MB_LANE_W +: MB_LANE_W];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= '0;
      else        cur_q <= nxt;
    end
    assign next_words[m] = nxt;
  end
endmodule

// File: rtl/mbox_cmd_port.sv
module mbox_cmd_port
  import mbox_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     trig,
  input  mb_word_t next_words [NUM_IN],
  input  logic     cmd_ack,
  output logic     cmd_valid,
  output mb_word_t snap [NUM_IN],
  output logic     pending,
  output logic     overrun,
  output logic     req_inc
);
  logic accept;
  logic ack_fire;

  assign accept   = trig && !pending;
  assign ack_fire = cmd_ack && pending;
  assign req_inc  = ack_fire && snap[NUM_IN-1][MB_REQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      pending   <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      cmd_valid <= accept;
      if (accept)        pending <= 1'b1;
      else if (ack_fire) pending <= 1'b0;
      if (trig && pending) overrun <= 1'b1;
    end
  end

  for (genvar m = 0; m < NUM_IN; m++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      snap[m] <= '0;
      else if (accept) snap[m] <= next_words[m];
    end
  end
endmodule

// File: rtl/mbox_req_ledger.sv
module mbox_req_ledger #(
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic has_req
);
  localparam logic [PEND_W-1:0] CAP = '1;
  logic [PEND_W-1:0] cnt;
  logic              inc_eff;

  assign inc_eff = inc && ((cnt != CAP) || dec);
  assign has_req = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + PEND_W'(inc_eff) - PEND_W'(dec);
  end
endmodule

// File: rtl/mbox_out_bank.sv
module mbox_out_bank
  import mbox_pkg::*;
#(
  parameter int NUM_OUT = 2,
  localparam int SEL_W  = $clog2(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               has_req,
  input  logic               resp_valid,
  output logic               resp_ready,
  input  mb_word_t           resp_data,
  input  logic [SEL_W-1:0]   resp_sel,
  output logic               resp_err,
  output logic               req_dec,
  output logic [NUM_OUT-1:0] ob_full,
  input  logic               hrd_en,
  input  logic [SEL_W-1:0]   hrd_sel,
  output mb_word_t           hrd_data
);
  mb_word_t box [NUM_OUT];
  logic     sel_full;
  mb_word_t rd_word;

  always_comb begin
    sel_full = 1'b0;
    rd_word  = '0;
    for (int k = 0; k < NUM_OUT; k++) begin
      if (resp_sel == SEL_W'(k)) sel_full = ob_full[k];
      if (hrd_sel == SEL_W'(k))  rd_word  = box[k];
    end
  end

  assign resp_ready = has_req ? !sel_full : 1'b1;
  assign req_dec    = resp_valid && has_req && !sel_full;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_ob
    logic     f_q;
    mb_word_t d_q;
    logic     wr_hit;
    logic     rd_hit;
    assign wr_hit = req_dec && (resp_sel == SEL_W'(k));
    assign rd_hit = hrd_en && (hrd_sel == SEL_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
        d_q <= '0;
      end else begin
        if (rd_hit) f_q <= 1'b0;
        if (wr_hit) begin
          f_q <= 1'b1;
          d_q <= resp_data;
        end
      end
    end
    assign ob_full[k] = f_q;
    assign box[k]     = d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hrd_data <= '0;
      resp_err <= 1'b0;
    end else begin
      if (hrd_en) hrd_data <= rd_word;
      if (resp_valid && !has_req) resp_err <= 1'b1;
    end
  end
endmodule

// File: rtl/mbox_cmd_resp.sv
module mbox_cmd_resp
  import mbox_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 2,
  parameter int PEND_W  = 3,
  localparam int IN_SEL_W  = $clog2(NUM_IN),
  localparam int OUT_SEL_W = $clog2(NUM_OUT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hwr_en,
  input  logic [IN_SEL_W-1:0]        hwr_sel,
  input  logic [MB_LANES-1:0]        hwr_be,
  input  logic [MB_WORD_W-1:0]       hwr_data,
  output logic                       cmd_valid,
  output logic [NUM_IN*MB_WORD_W-1:0] cmd_words,
  output logic                       cmd_pending,
  input  logic                       cmd_ack,
  output logic                       cmd_overrun,
  input  logic                       resp_valid,
  output logic                       resp_ready,
  input  logic [MB_WORD_W-1:0]       resp_data,
  input  logic [OUT_SEL_W-1:0]       resp_sel,
  output logic                       resp_err,
  output logic [NUM_OUT-1:0]         ob_full,
  input  logic                       hrd_en,
  input  logic [OUT_SEL_W-1:0]       hrd_sel,
  output logic [MB_WORD_W-1:0]       hrd_data
);
  mb_word_t next_words [NUM_IN];
  mb_word_t snap [NUM_IN];
  logic     trig;
  logic     req_inc;
  logic     req_dec;
  logic     has_req;

  mbox_in_bank #(.NUM_IN(NUM_IN)) u_in (
    .clk(clk), .rst_n(rst_n), .wr_en(hwr_en), .wr_sel(hwr_sel),
    .wr_be(hwr_be), .wr_data(hwr_data), .next_words(next_words), .trig(trig)
  );

  mbox_cmd_port #(.NUM_IN(NUM_IN)) u_cmd (
    .clk(clk), .rst_n(rst_n), .trig(trig), .next_words(next_words),
    .cmd_ack(cmd_ack), .cmd_valid(cmd_valid), .snap(snap),
    .pending(cmd_pending), .overrun(cmd_overrun), .req_inc(req_inc)
  );

  mbox_req_ledger #(.PEND_W(PEND_W)) u_ledger (
    .clk(clk), .rst_n(rst_n), .inc(req_inc), .dec(req_dec), .has_req(has_req)
  );

  mbox_out_bank #(.NUM_OUT(NUM_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .has_req(has_req),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .resp_sel(resp_sel), .resp_err(resp_err), .req_dec(req_dec),
    .ob_full(ob_full), .hrd_en(hrd_en), .hrd_sel(hrd_sel), .hrd_data(hrd_data)
  );

  for (genvar m = 0; m < NUM_IN; m++) begin : g_flat
    assign cmd_words[m*MB_WORD_W +: MB_WORD_W] = snap[m];
  end
endmodule

// File: rtl/mbox_cmd_resp_chk.sv
module mbox_cmd_resp_chk #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 2,
  localparam int IN_SEL_W  = $clog2(NUM_IN),
  localparam int OUT_SEL_W = $clog2(NUM_OUT)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hwr_en,
  input logic [IN_SEL_W-1:0]  hwr_sel,
  input logic [3:0]           hwr_be,
  input logic                 cmd_valid,
  input logic                 cmd_pending,
  input logic                 cmd_overrun,
  input logic                 resp_valid,
  input logic                 resp_ready,
  input logic [OUT_SEL_W-1:0] resp_sel,
  input logic                 resp_err,
  input logic [NUM_OUT-1:0]   ob_full,
  input logic                 hrd_en,
  input logic [OUT_SEL_W-1:0] hrd_sel
);
  logic trig_w;
  assign trig_w = hwr_en && (hwr_sel == IN_SEL_W'(NUM_IN - 1)) && hwr_be[3];

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R3
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_pending); // R4
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_w && cmd_pending) |=> (!cmd_valid && cmd_overrun)); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_overrun |=> cmd_overrun); // R5
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ready && ob_full[resp_sel]) |=> resp_err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |=> resp_err); // R9
  AST_READ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (hrd_en && !(resp_valid && resp_ready && resp_sel == hrd_sel))
      |=> !ob_full[$past(hrd_sel)]); // R10
endmodule

bind mbox_cmd_resp mbox_cmd_resp_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .hwr_en(hwr_en), .hwr_sel(hwr_sel), .hwr_be(hwr_be),
  .cmd_valid(cmd_valid), .cmd_pending(cmd_pending), .cmd_overrun(cmd_overrun),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_sel(resp_sel),
  .resp_err(resp_err), .ob_full(ob_full), .hrd_en(hrd_en), .hrd_sel(hrd_sel)
);

// File: tb/mbox_cmd_resp_test.sv
module mbox_cmd_resp_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hwr_en = 1'b0;
  logic [1:0] hwr_sel = '0;
  logic [3:0] hwr_be = '0;
  logic [31:0] hwr_data = '0;
  logic cmd_valid;
  logic [127:0] cmd_words;
  logic cmd_pending;
  logic cmd_ack = 1'b0;
  logic cmd_overrun;
  logic resp_valid = 1'b0;
  logic resp_ready;
  logic [31:0] resp_data = '0;
  logic resp_sel = 1'b0;
  logic resp_err;
  logic [1:0] ob_full;
  logic hrd_en = 1'b0;
  logic hrd_sel = 1'b0;
  logic [31:0] hrd_data;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  mbox_cmd_resp #(.NUM_IN(4), .NUM_OUT(2), .PEND_W(2)) uut (.*);

  // behavioural reference state
  logic [31:0] m_box [4];
  logic [31:0] m_snap [4];
  bit m_busy, m_cv, m_ovr, m_err;
  int m_req;
  bit m_obf [2];
  logic [31:0] m_obd [2];
  logic [31:0] m_hrd;

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_box[i] = '0; m_snap[i] = '0; end
    m_busy = 0; m_cv = 0; m_ovr = 0; m_err = 0; m_req = 0;
    for (int i = 0; i < 2; i++) begin m_obf[i] = 0; m_obd[i] = '0; end
    m_hrd = '0;
  endtask

  task automatic model_edge();
    bit trig, acc, ackf, has, wr;
    has  = (m_req > 0);
    wr   = resp_valid && has && !m_obf[resp_sel];
    trig = hwr_en && (hwr_sel == 2'd3) && hwr_be[3];
    acc  = trig && !m_busy;
    ackf = cmd_ack && m_busy;
    if (ackf && m_snap[3][31]) m_req++;
    if (wr) m_req--;
    if (m_req > 3) m_req = 3;
    if (hrd_en) begin m_hrd = m_obd[hrd_sel]; m_obf[hrd_sel] = 0; end
    if (wr) begin m_obf[resp_sel] = 1; m_obd[resp_sel] = resp_data; end
    if (resp_valid && !has) m_err = 1;
    if (hwr_en)
      for (int b = 0; b < 4; b++)
        if (hwr_be[b]) m_box[hwr_sel][b*8 +: 8] = hwr_data[b*8 +: 8];
    if (trig && m_busy) m_ovr = 1;
    m_cv = acc;
    if (acc) begin
      for (int i = 0; i < 4; i++) m_snap[i] = m_box[i];
      m_busy = 1;
    end else if (ackf) m_busy = 0;
  endtask

  task automatic compare_all();
    bit rdy;
    rdy = (m_req == 0) ? 1'b1 : !m_obf[resp_sel];
    chk("R3", "cmd_valid", 128'(cmd_valid), 128'(m_cv));
    chk("R3", "cmd_words", cmd_words, {m_snap[3], m_snap[2], m_snap[1], m_snap[0]});
    chk("R4", "cmd_pending", 128'(cmd_pending), 128'(m_busy));
    chk("R5", "cmd_overrun", 128'(cmd_overrun), 128'(m_ovr));
    chk("R8", "resp_ready", 128'(resp_ready), 128'(rdy));
    chk("R9", "resp_err", 128'(resp_err), 128'(m_err));
    chk("R7", "ob_full", 128'(ob_full), 128'({m_obf[1], m_obf[0]}));
    chk("R10", "hrd_data", 128'(hrd_data), 128'(m_hrd));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic hw(logic [1:0] sel, logic [3:0] be, logic [31:0] d);
    hwr_en = 1; hwr_sel = sel; hwr_be = be; hwr_data = d;
    cyc();
    hwr_en = 0; hwr_be = '0;
  endtask

  task automatic ack();
    cmd_ack = 1; cyc(); cmd_ack = 0;
  endtask

  task automatic rsp(logic s, logic [31:0] d);
    resp_valid = 1; resp_sel = s; resp_data = d; cyc(); resp_valid = 0;
  endtask

  task automatic rd(logic s);
    hrd_en = 1; hrd_sel = s; cyc(); hrd_en = 0;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cmd_valid", 128'(cmd_valid), 128'(0));
    chk("R1", "cmd_pending", 128'(cmd_pending), 128'(0));
    chk("R1", "flags", 128'({cmd_overrun, resp_err, ob_full}), 128'(0));
    chk("R1", "resp_ready", 128'(resp_ready), 128'(1));
    chk("R1", "hrd_data", 128'(hrd_data), 128'(0));

    // R2 plain writes, no trigger
    hw(2'd0, 4'hF, 32'h1111_1111);
    hw(2'd1, 4'hF, 32'h2222_2222);
    hw(2'd2, 4'hF, 32'h3333_3333);
    hw(2'd3, 4'h7, 32'h0044_4444);
    cyc();
    chk("R2", "no cmd_valid", 128'(cmd_valid), 128'(0));
    chk("R2", "no pending", 128'(cmd_pending), 128'(0));

    // R3 trigger with reply request bit
    hw(2'd3, 4'h8, 32'h8000_0000);
    chk("R3", "pulse", 128'(cmd_valid), 128'(1));
    chk("R3", "words", cmd_words, {32'h8044_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111});
    cyc();
    chk("R3", "pulse end", 128'(cmd_valid), 128'(0));
    chk("R4", "held", 128'(cmd_pending), 128'(1));

    // R5 trigger while busy
    hw(2'd3, 4'h8, 32'h0100_0000);
    chk("R5", "overrun", 128'(cmd_overrun), 128'(1));
    chk("R5", "no pulse", 128'(cmd_valid), 128'(0));
    chk("R5", "words kept", 128'(cmd_words[127:96]), 128'(32'h8044_4444));

    ack();
    chk("R4", "ack clears", 128'(cmd_pending), 128'(0));

    // R7 requested reply into empty mailbox
    chk("R7", "ready", 128'(resp_ready), 128'(1));
    rsp(1'b0, 32'hA000_0000);
    chk("R7", "ob_full", 128'(ob_full), 128'(2'b01));

    // R9 unrequested reply dropped
    resp_sel = 1'b1;
    @(posedge clk); @(negedge clk);
    model_edge(); compare_all();
    rsp(1'b1, 32'hBAD0_0000);
    chk("R9", "err", 128'(resp_err), 128'(1));
    chk("R9", "untouched", 128'(ob_full), 128'(2'b01));

    // R10 host read
    rd(1'b0);
    chk("R10", "data", 128'(hrd_data), 128'(32'hA000_0000));
    chk("R10", "freed", 128'(ob_full), 128'(2'b00));

    // R8 back-pressure on full mailbox (two requests)
    hw(2'd3, 4'h8, 32'h8000_0000); ack();
    hw(2'd3, 4'h8, 32'h8000_0000); ack();
    rsp(1'b0, 32'hC100_0001);
    resp_valid = 1; resp_sel = 1'b0; resp_data = 32'hC200_0002;
    #1;
    chk("R8", "ready low", 128'(resp_ready), 128'(0));
    cyc(); cyc();
    chk("R8", "still full", 128'(ob_full), 128'(2'b01));
    hrd_en = 1; hrd_sel = 1'b0; cyc(); hrd_en = 0;
    chk("R8", "first kept", 128'(hrd_data), 128'(32'hC100_0001));
    chk("R8", "ready after read", 128'(resp_ready), 128'(1));
    cyc();
    resp_valid = 0;
    rd(1'b0);
    chk("R7", "second stored", 128'(hrd_data), 128'(32'hC200_0002));

    // R4 ack while idle ignored, R6 command without request bit
    ack();
    hw(2'd3, 4'h8, 32'h0000_0000);
    chk("R4", "accepted after idle ack", 128'(cmd_valid), 128'(1));
    ack();
    rsp(1'b1, 32'hDEAD_0000);
    chk("R6", "no request added", 128'(ob_full), 128'(2'b00));

    // R6 saturation: four requests, only three replies accepted
    for (int i = 0; i < 4; i++) begin
      hw(2'd3, 4'h8, 32'h8000_0000); ack();
    end
    for (int i = 0; i < 4; i++) begin
      rsp(1'b0, 32'hE000_0000 + i);
      chk("R6", "sat fill", 128'(ob_full[0]), 128'(i < 3));
      rd(1'b0);
      if (i < 3) chk("R6", "sat data", 128'(hrd_data), 128'(32'hE000_0000 + i));
    end
    cyc(); cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule